// File: doc/BRIEF.md
# Z80 Bus Cycle Classifier and I/O Port Decoder

This block watches the five Z80 bus control strobes (memory request, I/O request, read, write and M1, all active low). It names the kind of bus cycle under way as a 3-bit code. The code is available both combinationally and as a copy registered on each clock edge.

For genuine IN/OUT cycles only, the block also decodes peripheral port selects from the upper nibble of the low address byte. Each of the five peripheral ranges gets its own active-low read strobe and its own active-low write strobe. An interrupt acknowledge also drives I/O request low, but it carries M1 low as well; it is classified separately and never selects a port.

Top module: `z80_io_cycle_decode`

## Requirements
- R1: With all five strobes high, the cycle code is 0 (idle).
- R2: The memory cycles are coded as follows, each with I/O request high. Memory request, read and M1 low with write high gives code 1 (opcode fetch). Memory request and read low with write and M1 high gives code 2 (memory read). Memory request and write low with read and M1 high gives code 3 (memory write).
- R3: I/O request and read low, with memory request, write and M1 high, gives code 4 (I/O read). I/O request and write low, with memory request, read and M1 high, gives code 5 (I/O write).
- R4: I/O request and M1 both low, with memory request high, gives code 6 (interrupt acknowledge) whatever the read and write levels are. Such a cycle asserts no port strobe.
- R5: Every other strobe combination gives code 7 (invalid), and no port strobe is asserted.
- R6: Address bits [7:4] pick the port index: value 0 picks index 0, 1 picks index 1, 2 picks index 2, 3 picks index 3 and 7 picks index 4. Address bits [3:0] have no effect on any strobe.
- R7: Nibble values 4, 5, 6 and 8 through 15 assert no port strobe.
- R8: Bit i of the read strobe vector goes low only during an I/O read cycle that hits port index i. Bit i of the write strobe vector goes low only during an I/O write cycle that hits index i. At most one strobe across both vectors is low at any time.
- R9: The registered code equals the combinational code sampled at the previous rising clock edge. While reset is held it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mreq_ni | input | 1 | Memory request, active low |
| iorq_ni | input | 1 | I/O request, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| m1_ni | input | 1 | M1 / opcode fetch, active low |
| addr_i | input | ADDR_W (8) | Low byte of the address bus |
| cyc_o | output | 3 | Combinational cycle code |
| cyc_q_o | output | 3 | Registered cycle code |
| port_rd_no | output | 5 | Read-qualified port strobes, active low |
| port_wr_no | output | 5 | Write-qualified port strobes, active low |

## Verification
The bench builds the block with the default ADDR_W of 8, so the whole low address byte is only 256 values. Combined with the 32 strobe patterns, this makes an exhaustive sweep of all 8192 input combinations cheap. That sweep covers every interrupt-acknowledge variant, every invalid pattern and every unused nibble. A seeded random phase follows, which changes the address and strobes on every cycle, so the registered code is checked against back-to-back changes of cycle type.

// File: rtl/z80_io_pkg.sv
package z80_io_pkg;
  localparam int CYC_W  = 3;
  localparam int NIB_W  = 4;
  localparam int PORT_N = 5;

  typedef enum logic [CYC_W-1:0] {
    CYC_IDLE  = 3'd0,
    CYC_FETCH = 3'd1,
    CYC_MRD   = 3'd2,
    CYC_MWR   = 3'd3,
    CYC_IORD  = 3'd4,
    CYC_IOWR  = 3'd5,
    CYC_INTA  = 3'd6,
    CYC_BAD   = 3'd7
  } cyc_e;

  // nibble value decoded for each port index
  function automatic logic [NIB_W-1:0] port_nib(input int idx);
    case (idx)
      0: port_nib = 4'h0;
      1: port_nib = 4'h1;
      2: port_nib = 4'h2;
      3: port_nib = 4'h3;
      default: port_nib = 4'h7;
    endcase
  endfunction
endpackage

// File: rtl/z80_cycle_classify.sv
module z80_cycle_classify
  import z80_io_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mreq_ni,
  input  logic iorq_ni,
  input  logic rd_ni,
  input  logic wr_ni,
  input  logic m1_ni,
  output cyc_e cyc_o
);
  always_comb begin
    unique case ({mreq_ni, iorq_ni, rd_ni, wr_ni, m1_ni})
      5'b11111: cyc_o = CYC_IDLE;
      5'b01010: cyc_o = CYC_FETCH;
      5'b01011: cyc_o = CYC_MRD;
      5'b01101: cyc_o = CYC_MWR;
      5'b10011: cyc_o = CYC_IORD;
      5'b10101: cyc_o = CYC_IOWR;
      default:  cyc_o = (!iorq_ni && !m1_ni && mreq_ni) ? CYC_INTA : CYC_BAD;
    endcase
  end

  AST_INTA_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iorq_ni && !m1_ni && mreq_ni) |-> cyc_o == CYC_INTA); // R4
  AST_IO_NEEDS_IORQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o == CYC_IORD || cyc_o == CYC_IOWR) |-> (!iorq_ni && m1_ni && mreq_ni)); // R3
  AST_BOTH_REQ_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iorq_ni && !mreq_ni) |-> cyc_o == CYC_BAD); // R5
endmodule

// File: rtl/z80_port_decode.sv
module z80_port_decode
  import z80_io_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cyc_e              cyc_i,
  input  logic [NIB_W-1:0]  nib_i,
  output logic [PORT_N-1:0] rd_no,
  output logic [PORT_N-1:0] wr_no
);
  for (genvar i = 0; i < PORT_N; i++) begin : g_port
    logic hit;
    assign hit      = (nib_i == port_nib(i));
    assign rd_no[i] = ~(hit && cyc_i == CYC_IORD);
    assign wr_no[i] = ~(hit && cyc_i == CYC_IOWR);
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~{rd_no, wr_no})); // R8
  AST_UNUSED_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib_i inside {4'h4, 4'h5, 4'h6} || nib_i >= 4'h8) |-> (&rd_no && &wr_no)); // R7
  AST_RD_ONLY_IORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&rd_no) |-> cyc_i == CYC_IORD); // R8
endmodule

// File: rtl/z80_io_cycle_decode.sv
module z80_io_cycle_decode
  import z80_io_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mreq_ni,
  input  logic                iorq_ni,
  input  logic                rd_ni,
  input  logic                wr_ni,
  input  logic                m1_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [2:0]          cyc_o,
  output logic [2:0]          cyc_q_o,
  output logic [4:0]          port_rd_no,
  output logic [4:0]          port_wr_no
);
  localparam int LO_W = ADDR_W - NIB_W;

  cyc_e cyc;
  cyc_e cyc_q;

  z80_cycle_classify u_cls (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mreq_ni (mreq_ni),
    .iorq_ni (iorq_ni),
    .rd_ni   (rd_ni),
    .wr_ni   (wr_ni),
    .m1_ni   (m1_ni),
    .cyc_o   (cyc)
  );

  z80_port_decode u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cyc_i  (cyc),
    .nib_i  (addr_i[ADDR_W-1 -: NIB_W]),
    .rd_no  (port_rd_no),
    .wr_no  (port_wr_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= CYC_IDLE;
    else         cyc_q <= cyc;
  end

  assign cyc_o   = cyc;
  assign cyc_q_o = cyc_q;

  AST_REG_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cyc_q_o == $past(cyc_o)); // R9
  AST_INTA_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_o == 3'd6 |-> (&port_rd_no && &port_wr_no)); // R4
  AST_LOW_BITS_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(addr_i[LO_W-1:0]) && $stable(addr_i[ADDR_W-1 -: NIB_W]) && $stable(cyc_o))
      |-> $stable({port_rd_no, port_wr_no})); // R6
endmodule

// File: tb/z80_io_cycle_decode_test.sv
module z80_io_cycle_decode_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mreq_ni = 1'b1, iorq_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1, m1_ni = 1'b1;
  logic [7:0] addr_i = 8'h00;
  logic [2:0] cyc_o, cyc_q_o;
  logic [4:0] port_rd_no, port_wr_no;

  int n_chk = 0;
  int n_fail = 0;
  logic [2:0] prev_exp;

  always #10 clk_i = ~clk_i;

  z80_io_cycle_decode #(.ADDR_W(8)) uut (.*);

  function automatic logic [2:0] exp_cyc(input logic mq, iq, r, w, m);
    if (mq & iq & r & w & m) return 3'd0;
    if (!iq && !m && mq) return 3'd6;
    if (!mq && iq && !r && w && !m) return 3'd1;
    if (!mq && iq && !r && w && m) return 3'd2;
    if (!mq && iq && r && !w && m) return 3'd3;
    if (mq && !iq && !r && w && m) return 3'd4;
    if (mq && !iq && r && !w && m) return 3'd5;
    return 3'd7;
  endfunction

  function automatic int exp_idx(input logic [7:0] a);
    case (a[7:4])
      4'h0: return 0;
      4'h1: return 1;
      4'h2: return 2;
      4'h3: return 3;
      4'h7: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply at negedge, check registered code of previous vector, then comb outputs
  task automatic apply(input logic [4:0] ctl, input logic [7:0] a);
    logic [2:0] c;
    int k;
    logic [4:0] erd, ewr;
    @(negedge clk_i);
    chk("R9 registered code", {7'd0, cyc_q_o}, {7'd0, prev_exp});
    {mreq_ni, iorq_ni, rd_ni, wr_ni, m1_ni} = ctl;
    addr_i = a;
    #5;
    c = exp_cyc(ctl[4], ctl[3], ctl[2], ctl[1], ctl[0]);
    k = exp_idx(a);
    erd = 5'h1f; ewr = 5'h1f;
    if (k >= 0 && c == 3'd4) erd[k] = 1'b0;
    if (k >= 0 && c == 3'd5) ewr[k] = 1'b0;
    chk(c == 3'd6 ? "R4 inta" : c == 3'd7 ? "R5 invalid" : c >= 3'd4 ? "R3 io code" :
        c == 3'd0 ? "R1 idle" : "R2 mem code", {7'd0, cyc_o}, {7'd0, c});
    chk(k < 0 ? "R7 unused range" : "R6/R8 port strobes",
        {port_rd_no, port_wr_no}, {erd, ewr});
    prev_exp = c;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // reset holds registered code at idle despite an I/O read on the bus
    {mreq_ni, iorq_ni, rd_ni, wr_ni, m1_ni} = 5'b10011;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R9 reset idle", {7'd0, cyc_q_o}, 10'd0);
    {mreq_ni, iorq_ni, rd_ni, wr_ni, m1_ni} = 5'b11111;
    @(negedge clk_i);
    rst_ni = 1'b1;
    prev_exp = 3'd0;
    // directed corners
    apply(5'b10011, 8'h7f);   // R3/R6 bank switch read, low bits set
    apply(5'b10101, 8'h70);   // R3/R6 bank switch write
    apply(5'b10010, 8'h00);   // R4 inta with rd low
    apply(5'b10110, 8'h10);   // R4 inta
    apply(5'b10011, 8'h4a);   // R7
    apply(5'b10011, 8'hf3);   // R7
    apply(5'b00011, 8'h20);   // R5 both requests
    apply(5'b10001, 8'h30);   // R5 rd and wr both low
    // exhaustive sweep
    for (int ctl = 0; ctl < 32; ctl++)
      for (int a = 0; a < 256; a++)
        apply(ctl[4:0], a[7:0]);
    // seeded random
    for (int i = 0; i < 3000; i++)
      apply($urandom_range(31, 0), $urandom_range(255, 0));
    @(negedge clk_i);
    chk("R9 registered code", {7'd0, cyc_q_o}, {7'd0, prev_exp});
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule